// File: doc/BRIEF.md
# ADC Peripheral Register Front-End

This block is the byte-wide register face of a current-sense converter. A host
reaches it over a plain single-cycle bus with an address, write data, a write
strobe, a read strobe and combinational read data. Through it the host finds
fixed identification bytes and sets up the mode, trim, decimation, settle time,
averaging, input selection and converter enable. It can then request one
conversion, poll a status byte or wait for a one-cycle end-of-conversion pulse,
and fetch a 16-bit result as two bytes.

The analog part is replaced by a stub. The stub captures the latency input when
a conversion starts. Each sample takes latency+1 cycles. When averaging is
active, a conversion covers 2^count samples. At the final edge the stub latches
the sample input as the result. A reset-control byte is guarded by a key: it
takes a write only when the bus write just before it was the key.

Top module: `adc_regfront`

## Requirements
- R1: Reads of offset 0x01 return 0x01, 0x04 return 0x08 and 0x05 return 0x03. Writes to these offsets do not change what they read.
- R2: A read of any offset outside the map returns 0x00. A write to such an offset changes no readable register. The map is 0x01, 0x04, 0x05, 0x08, 0x40, 0x46, 0x48, 0x50, 0x51, 0x52, 0x5A, 0x5B, 0x60, 0x61, 0xD0 and 0xDA. Of these, 0x52 and 0xD0 always read 0x00.
- R3: After reset every register other than the identification bytes reads 0x00. Control bytes read back the written value ANDed with a field mask. The masks are: 0x40 with 0xF9 (mode in bits 7:3, trim in bit 0), 0x50 with 0x0C (decimation in bits 3:2), 0x51 with 0xFF, 0x5A with 0x07 (averaging count), 0x5B with 0x80 (averaging enable) and 0x46 with 0x80 (converter enable).
- R4: Offset 0x48 stores a write only when the whole byte is 0, 1, 3, 5 or 6. These codes select internal sense, external sense, gain reference, external offset and internal offset. Any other write leaves the stored code unchanged.
- R5: Writing 0xA5 to 0xD0 arms the key, and the very next bus write disarms it, whatever that write is. A write to 0xDA lands only while the key is armed. 0xDA reads back its stored byte.
- R6: A write to 0x52 with bit 7 set starts a conversion only when 0x46 bit 7 is set and no conversion is pending. Status byte 0x08 then reads bits[1:0] = 2'b10 (bit 1 pending, bit 0 done). A request while the enable is clear, or without bit 7 set, does nothing.
- R7: A conversion started at edge E finishes at edge E + S*(L+1). L is the latency input. S is 2^count when 0x5B bit 7 is set and the count is nonzero, and 1 otherwise. At the finish the status reads 2'b01, 0x60 returns the low byte of the sample input and 0x61 returns the high byte.
- R8: eoc_irq is high for exactly one cycle, in the cycle that done first reads 1, with one pulse per finished conversion.
- R9: Writing 0x46 with bit 7 clear aborts a running conversion. Pending clears at once, done stays 0 and no eoc_irq pulse follows.
- R10: A request made while a conversion is pending is ignored and does not move its finish time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_re | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 8 | Combinational read data |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |
| stub_sample | input | 16 | Value the converter stub returns |
| stub_latency | input | LAT_W | Cycles per sample minus one, captured at start |

## Verification
The properties assume that at most one write strobe arrives per cycle and that the address and write data are valid while it is high. They also assume that the stub sample input is stable around the finishing edge of a conversion. The stimulus drives every bus input on the falling clock edge and keeps each write to a single rising edge. It sets the stub inputs before each request and leaves them untouched until the result has been read. Reads are combinational and have no side effects, so the bench checks status at exact edge counts without disturbing the conversion timing.

// File: rtl/adc_regfront_pkg.sv
package adc_regfront_pkg;

    localparam int RES_W     = 16;
    localparam int RES_BYTES = RES_W / 8;

    localparam logic [7:0] A_REV     = 8'h01;
    localparam logic [7:0] A_TYPE    = 8'h04;
    localparam logic [7:0] A_SUBTYPE = 8'h05;
    localparam logic [7:0] A_STATUS  = 8'h08;
    localparam logic [7:0] A_MODE    = 8'h40;
    localparam logic [7:0] A_ENABLE  = 8'h46;
    localparam logic [7:0] A_CHAN    = 8'h48;
    localparam logic [7:0] A_DECIM   = 8'h50;
    localparam logic [7:0] A_SETTLE  = 8'h51;
    localparam logic [7:0] A_REQ     = 8'h52;
    localparam logic [7:0] A_AVGCNT  = 8'h5A;
    localparam logic [7:0] A_AVGEN   = 8'h5B;
    localparam logic [7:0] A_RESULT  = 8'h60;
    localparam logic [7:0] A_KEY     = 8'hD0;
    localparam logic [7:0] A_RSTCTL  = 8'hDA;

    localparam logic [7:0] ID_REV     = 8'h01;
    localparam logic [7:0] ID_TYPE    = 8'h08;
    localparam logic [7:0] ID_SUBTYPE = 8'h03;
    localparam logic [7:0] KEY_VALUE  = 8'hA5;

    typedef enum logic [2:0] {
        CH_INT_SENSE  = 3'd0,
        CH_EXT_SENSE  = 3'd1,
        CH_GAIN_REF   = 3'd3,
        CH_EXT_OFFSET = 3'd5,
        CH_INT_OFFSET = 3'd6
    } chan_e;

    typedef enum logic {
        CV_IDLE = 1'b0,
        CV_RUN  = 1'b1
    } conv_state_e;

    typedef struct packed {
        logic [4:0] op_mode;
        logic       trim;
        logic [1:0] decim;
        logic [7:0] settle;
        logic       avg_en;
        logic       en;
        chan_e      chan;
    } ctrl_t;

    typedef struct packed {
        logic pending;
        logic done;
    } status_t;

    function automatic logic chan_ok(input logic [7:0] code);
        return (code == 8'd0) || (code == 8'd1) || (code == 8'd3) ||
               (code == 8'd5) || (code == 8'd6);
    endfunction

endpackage

// File: rtl/adc_rf_keyguard.sv
module adc_rf_keyguard
    import adc_regfront_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       armed,
    output logic       wr_ok
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (we) begin
            armed_q <= (addr == A_KEY) && (wdata == KEY_VALUE);
        end
    end

    assign armed = armed_q;
    assign wr_ok = we && (addr == A_RSTCTL) && armed_q;

endmodule

// File: rtl/adc_rf_conv_stub.sv
module adc_rf_conv_stub
    import adc_regfront_pkg::*;
#(
    parameter int LAT_W = 8,
    parameter int AVG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [AVG_W-1:0] avg_log2,
    input  logic [LAT_W-1:0] latency,
    input  logic [RES_W-1:0] sample,
    output status_t          status,
    output logic [RES_W-1:0] result,
    output logic             eoc
);

    localparam int LEFT_W = 1 << AVG_W;

    conv_state_e       state_q;
    logic              done_q;
    logic              eoc_q;
    logic [LAT_W-1:0]  lat_q;
    logic [LAT_W-1:0]  cnt_q;
    logic [LEFT_W-1:0] left_q;
    logic [RES_W-1:0]  result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CV_IDLE;
            done_q   <= 1'b0;
            eoc_q    <= 1'b0;
            lat_q    <= '0;
            cnt_q    <= '0;
            left_q   <= '0;
            result_q <= '0;
        end else begin
            eoc_q <= 1'b0;
            if (abort) begin
                state_q <= CV_IDLE;
            end else if (start && state_q == CV_IDLE) begin
                state_q <= CV_RUN;
                done_q  <= 1'b0;
                lat_q   <= latency;
                cnt_q   <= latency;
                left_q  <= (LEFT_W'(1) << avg_log2) - LEFT_W'(1);
            end else if (state_q == CV_RUN) begin
                if (cnt_q == '0) begin
                    if (left_q == '0) begin
                        state_q  <= CV_IDLE;
                        done_q   <= 1'b1;
                        eoc_q    <= 1'b1;
                        result_q <= sample;
                    end else begin
                        left_q <= left_q - LEFT_W'(1);
                        cnt_q  <= lat_q;
                    end
                end else begin
                    cnt_q <= cnt_q - LAT_W'(1);
                end
            end
        end
    end

    assign status.pending = (state_q == CV_RUN);
    assign status.done    = done_q;
    assign result         = result_q;
    assign eoc            = eoc_q;

endmodule

// File: rtl/adc_regfront.sv
module adc_regfront
    import adc_regfront_pkg::*;
#(
    parameter int LAT_W = 8,
    parameter int AVG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_we,
    input  logic             bus_re,
    output logic [7:0]       bus_rdata,
    output logic             eoc_irq,
    input  logic [15:0]      stub_sample,
    input  logic [LAT_W-1:0] stub_latency
);

    ctrl_t            ctrl_q;
    logic [AVG_W-1:0] avg_cnt_q;
    logic [7:0]       rstctl_q;
    logic             key_armed;
    logic             rst_wr_ok;
    logic             en_q;
    logic             conv_start;
    logic             conv_abort;
    logic [AVG_W-1:0] avg_log2;
    status_t          conv_status;
    logic             conv_pending;
    logic             conv_done;
    logic [RES_W-1:0] conv_result;
    logic [7:0]       rd_byte;

    assign en_q = ctrl_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            avg_cnt_q <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                A_MODE: begin
                    ctrl_q.op_mode <= bus_wdata[7:3];
                    ctrl_q.trim    <= bus_wdata[0];
                end
                A_DECIM:  ctrl_q.decim  <= bus_wdata[3:2];
                A_SETTLE: ctrl_q.settle <= bus_wdata;
                A_AVGCNT: avg_cnt_q     <= bus_wdata[AVG_W-1:0];
                A_AVGEN:  ctrl_q.avg_en <= bus_wdata[7];
                A_ENABLE: ctrl_q.en     <= bus_wdata[7];
                A_CHAN: begin
                    if (chan_ok(bus_wdata)) begin
                        ctrl_q.chan <= chan_e'(bus_wdata[2:0]);
                    end
                end
                default: ;
            endcase
        end
    end

    adc_rf_keyguard u_key (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .armed (key_armed),
        .wr_ok (rst_wr_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rstctl_q <= '0;
        end else if (rst_wr_ok) begin
            rstctl_q <= bus_wdata;
        end
    end

    assign conv_start = bus_we && (bus_addr == A_REQ) && bus_wdata[7] && ctrl_q.en;
    assign conv_abort = bus_we && (bus_addr == A_ENABLE) && !bus_wdata[7];
    assign avg_log2   = (ctrl_q.avg_en && avg_cnt_q != '0) ? avg_cnt_q : '0;

    adc_rf_conv_stub #(
        .LAT_W (LAT_W),
        .AVG_W (AVG_W)
    ) u_conv (
        .clk      (clk),
        .rst      (rst),
        .start    (conv_start),
        .abort    (conv_abort),
        .avg_log2 (avg_log2),
        .latency  (stub_latency),
        .sample   (stub_sample),
        .status   (conv_status),
        .result   (conv_result),
        .eoc      (eoc_irq)
    );

    assign conv_pending = conv_status.pending;
    assign conv_done    = conv_status.done;

    always_comb begin
        rd_byte = 8'h00;
        unique case (bus_addr)
            A_REV:     rd_byte = ID_REV;
            A_TYPE:    rd_byte = ID_TYPE;
            A_SUBTYPE: rd_byte = ID_SUBTYPE;
            A_STATUS:  rd_byte = {6'b0, conv_pending, conv_done};
            A_MODE:    rd_byte = {ctrl_q.op_mode, 2'b00, ctrl_q.trim};
            A_DECIM:   rd_byte = {4'b0, ctrl_q.decim, 2'b00};
            A_SETTLE:  rd_byte = ctrl_q.settle;
            A_AVGCNT:  rd_byte = {{(8-AVG_W){1'b0}}, avg_cnt_q};
            A_AVGEN:   rd_byte = {ctrl_q.avg_en, 7'b0};
            A_ENABLE:  rd_byte = {ctrl_q.en, 7'b0};
            A_CHAN:    rd_byte = {5'b0, ctrl_q.chan};
            A_RSTCTL:  rd_byte = rstctl_q;
            default:   rd_byte = 8'h00;
        endcase
        for (int b = 0; b < RES_BYTES; b++) begin
            if (bus_addr == A_RESULT + 8'(b)) begin
                rd_byte = conv_result[8*b +: 8];
            end
        end
    end

    assign bus_rdata = bus_re ? rd_byte : 8'h00;

endmodule

// File: rtl/adc_rf_checker.sv
module adc_rf_checker
    import adc_regfront_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_we,
    input logic       bus_re,
    input logic [7:0] bus_rdata,
    input logic       eoc_irq,
    input logic       en,
    input logic       armed,
    input logic [7:0] rst_ctl,
    input logic       pending,
    input logic       done
);

    p_id_type_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == A_TYPE) |-> (bus_rdata == ID_TYPE));

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == 8'hFF) |-> (bus_rdata == 8'h00));

    p_locked_rstctl_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_RSTCTL && !armed) |=> $stable(rst_ctl));

    p_start_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_REQ && bus_wdata[7] && en && !pending)
        |=> (pending && !done));

    p_ignore_disabled_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_REQ && !en && !pending) |=> !pending);

    p_status_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(pending && done));

    p_irq_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |-> (done && !pending));

    p_done_raises_irq_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> eoc_irq);

    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |=> !eoc_irq);

    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_ENABLE && !bus_wdata[7]) |=> (!pending && !eoc_irq));

endmodule

bind adc_regfront adc_rf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .eoc_irq   (eoc_irq),
    .en        (en_q),
    .armed     (key_armed),
    .rst_ctl   (rstctl_q),
    .pending   (conv_pending),
    .done      (conv_done)
);

// File: tb/sim_adc_regfront.sv
`timescale 1ns/1ps
module sim_adc_regfront;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       eoc_irq;
    logic [15:0] stub_sample = 16'h0000;
    logic [7:0]  stub_latency = 8'h00;

    int tests = 0;
    int fails = 0;
    int irq_count = 0;

    always #10 clk = ~clk;

    adc_regfront u0 (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .bus_re       (bus_re),
        .bus_rdata    (bus_rdata),
        .eoc_irq      (eoc_irq),
        .stub_sample  (stub_sample),
        .stub_latency (stub_latency)
    );

    always @(negedge clk) if (eoc_irq) irq_count++;

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        bus_addr = a; bus_re = 1'b1;
        #1;
        v = int'(bus_rdata);
        bus_re = 1'b0;
    endtask

    function automatic bit mapped(input int a);
        return a == 8'h01 || a == 8'h04 || a == 8'h05 || a == 8'h08 ||
               a == 8'h40 || a == 8'h46 || a == 8'h48 || a == 8'h50 ||
               a == 8'h51 || a == 8'h52 || a == 8'h5A || a == 8'h5B ||
               a == 8'h60 || a == 8'h61 || a == 8'hD0 || a == 8'hDA;
    endfunction

    function automatic int id_value(input int a);
        case (a)
            8'h01:   return 1;
            8'h04:   return 8;
            8'h05:   return 3;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_id(input int a);
        return a == 8'h01 || a == 8'h04 || a == 8'h05;
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int v;
        int chan_exp;
        int irq0;
        int s;
        int t;
        int idx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // R1 R2 R3: reset-state sweep over every offset
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), v);
            if (is_id(a))        check("R1 id read", v, id_value(a));
            else if (mapped(a))  check("R3 reset value", v, 0);
            else                 check("R2 unmapped read", v, 0);
        end

        // R1: identification bytes ignore writes
        wr(8'h01, 8'hFF); wr(8'h04, 8'h00); wr(8'h05, 8'h77);
        rd(8'h01, v); check("R1 rev after write", v, 1);
        rd(8'h04, v); check("R1 type after write", v, 8);
        rd(8'h05, v); check("R1 subtype after write", v, 3);

        // R2: writes to every unmapped offset change nothing readable
        for (int a = 0; a < 256; a++) begin
            if (!mapped(a)) wr(8'(a), 8'hFF);
        end
        for (int a = 0; a < 256; a++) begin
            if (mapped(a)) begin
                rd(8'(a), v);
                check("R2 mapped after unmapped writes", v, id_value(a));
            end
        end

        // R3: field masks
        wr(8'h40, 8'hFF); wr(8'h50, 8'hFF); wr(8'h51, 8'hFF);
        wr(8'h5A, 8'hFF); wr(8'h5B, 8'hFF); wr(8'h46, 8'hFF);
        rd(8'h40, v); check("R3 mode mask", v, 8'hF9);
        rd(8'h50, v); check("R3 decim mask", v, 8'h0C);
        rd(8'h51, v); check("R3 settle", v, 8'hFF);
        rd(8'h5A, v); check("R3 avg count mask", v, 8'h07);
        rd(8'h5B, v); check("R3 avg enable mask", v, 8'h80);
        rd(8'h46, v); check("R3 enable mask", v, 8'h80);
        wr(8'h40, 8'h5A); wr(8'h50, 8'h37); wr(8'h51, 8'h3C);
        wr(8'h5A, 8'h05); wr(8'h5B, 8'h7F); wr(8'h46, 8'h00);
        rd(8'h40, v); check("R3 mode pattern", v, 8'h5A & 8'hF9);
        rd(8'h50, v); check("R3 decim pattern", v, 8'h37 & 8'h0C);
        rd(8'h51, v); check("R3 settle pattern", v, 8'h3C);
        rd(8'h5A, v); check("R3 avg count pattern", v, 8'h05);
        rd(8'h5B, v); check("R3 avg enable cleared", v, 8'h00);
        rd(8'h46, v); check("R3 enable cleared", v, 8'h00);

        // R4: channel code sweep
        wr(8'h48, 8'h03);
        chan_exp = 3;
        for (int c = 0; c < 8; c++) begin
            wr(8'h48, 8'(c));
            if (c == 0 || c == 1 || c == 3 || c == 5 || c == 6) chan_exp = c;
            rd(8'h48, v); check("R4 channel code", v, chan_exp);
        end
        wr(8'h48, 8'h13);
        rd(8'h48, v); check("R4 channel out-of-set byte", v, chan_exp);

        // R5: key-guarded reset-control byte
        wr(8'hDA, 8'h5A);
        rd(8'hDA, v); check("R5 locked write", v, 0);
        wr(8'hD0, 8'hA5); wr(8'hDA, 8'h3C);
        rd(8'hDA, v); check("R5 unlocked write", v, 8'h3C);
        wr(8'hDA, 8'h11);
        rd(8'hDA, v); check("R5 key consumed", v, 8'h3C);
        wr(8'hD0, 8'hA5); wr(8'h40, 8'h08); wr(8'hDA, 8'h77);
        rd(8'hDA, v); check("R5 key consumed by other write", v, 8'h3C);
        rd(8'h40, v); check("R5 intervening write landed", v, 8'h08);
        wr(8'hD0, 8'hA4); wr(8'hDA, 8'h66);
        rd(8'hDA, v); check("R5 wrong key", v, 8'h3C);
        wr(8'hD0, 8'hA5); wr(8'hD0, 8'hA5); wr(8'hDA, 8'h42);
        rd(8'hDA, v); check("R5 double key", v, 8'h42);
        rd(8'hD0, v); check("R5 key reads zero", v, 0);

        // R6: requests while disabled or without bit 7
        irq0 = irq_count;
        wr(8'h52, 8'h80);
        rd(8'h08, v); check("R6 request while disabled", v, 0);
        wr(8'h46, 8'h80);
        wr(8'h52, 8'h7F);
        rd(8'h08, v); check("R6 request without bit 7", v, 0);
        repeat (4) tick();
        check("R6 no irq from ignored requests", irq_count, irq0);

        // R7 R8: timing sweep over averaging and latency
        idx = 0;
        for (int ae = 0; ae < 2; ae++) begin
            for (int cnt = 0; cnt < 4; cnt++) begin
                for (int lat = 0; lat < 4; lat++) begin
                    stub_latency = 8'(lat);
                    stub_sample  = 16'(16'h1234 + idx * 16'h0517);
                    wr(8'h5A, 8'(cnt));
                    wr(8'h5B, ae != 0 ? 8'h80 : 8'h00);
                    irq0 = irq_count;
                    wr(8'h52, 8'h80);
                    rd(8'h08, v); check("R6 pending after request", v, 2);
                    s = (ae != 0 && cnt != 0) ? (1 << cnt) : 1;
                    t = s * (lat + 1);
                    repeat (t - 1) tick();
                    rd(8'h08, v); check("R7 pending one cycle before finish", v, 2);
                    tick();
                    rd(8'h08, v); check("R7 done at finish", v, 1);
                    check("R8 irq high with done", int'(eoc_irq), 1);
                    rd(8'h60, v); check("R7 result low byte", v, int'(stub_sample[7:0]));
                    rd(8'h61, v); check("R7 result high byte", v, int'(stub_sample[15:8]));
                    tick();
                    check("R8 irq one cycle", int'(eoc_irq), 0);
                    check("R8 one pulse per conversion", irq_count, irq0 + 1);
                    idx++;
                end
            end
        end

        // R10: request while pending does not restart
        wr(8'h5B, 8'h00);
        stub_latency = 8'd3;
        wr(8'h52, 8'h80);
        wr(8'h52, 8'h80);
        tick();
        rd(8'h08, v); check("R10 still pending", v, 2);
        tick();
        rd(8'h08, v); check("R10 finish time unchanged", v, 1);

        // R9: abort by clearing enable
        stub_latency = 8'd5;
        irq0 = irq_count;
        wr(8'h52, 8'h80);
        wr(8'h46, 8'h00);
        rd(8'h08, v); check("R9 abort clears pending", v, 0);
        repeat (10) tick();
        rd(8'h08, v); check("R9 no done after abort", v, 0);
        check("R9 no irq after abort", irq_count, irq0);
        wr(8'h52, 8'h80);
        rd(8'h08, v); check("R6 request after abort while disabled", v, 0);

        summary();
    end

endmodule